// File: doc/BRIEF.md
# Bus Parity Generator and Error Reporter

This block produces and checks even parity for a shared 32-bit address/data bus and its 4-bit command/byte-enable lane, on behalf of a device that can be either the initiator or the target of a transaction. In each clock it looks at the device's role, the transaction direction and the phase on the bus. From these it decides whether the device must drive the parity bit on the following clock or compare the parity bit that another agent drives.

A data phase counts only on a clock where both ready handshakes are high. A data parity mismatch during a read by the initiator or a write to the target pulls the low-active error line for one clock, provided error reporting is enabled. A sticky status bit records every mismatch, whether or not reporting is enabled. When the device writes as initiator, the block watches the error line that the target drives and records any report in a second sticky bit. Both sticky bits are cleared by write-one-to-clear strobes.

Top module: `bus_parity_unit`

## Requirements
- R1: In the clock after a phase that the device drives, `par_o` equals the XOR of all 32 `ad_i` bits and all 4 `cbe_i` bits sampled in that phase, so the 37 bits together hold an even number of ones.
- R2: `par_oe_o` is high for one clock after each of these, and low otherwise: an address phase with `is_master_i`=1; a completed data phase with `is_master_i`=1 and `is_write_i`=1; a completed data phase with `is_master_i`=0 and `is_write_i`=0.
- R3: A data phase (`addr_phase_i`=0) is completed only when `irdy_i` and `trdy_i` are both 1 in the same clock. A phase that is not completed drives nothing and checks nothing.
- R4: `par_i` is compared, in the clock after the phase, with the parity of that phase's bus value for three cases: an address phase with `is_master_i`=0, a completed master read data phase, and a completed target write data phase.
- R5: A data-phase mismatch from R4 drives `perr_n_o`=0 and `perr_oe_o`=1 for exactly one clock, two clocks after the phase. This happens only if `rpt_en_i` was 1 in the phase clock. An address-phase mismatch never drives the error line.
- R6: `par_err_det_o` becomes 1 two clocks after any mismatch from R4, including address phases and phases with `rpt_en_i`=0. It stays 1 until cleared.
- R7: In the clock two clocks after a completed master write data phase, `perr_n_i`=0 makes `tgt_perr_o` 1 from the next clock onward. A low `perr_n_i` at any other time is ignored.
- R8: `clr_i[0]`=1 clears `par_err_det_o` and `clr_i[1]`=1 clears `tgt_perr_o` at the next clock edge. If a set and a clear reach the same bit in the same clock, the set wins.
- R9: After reset, `par_oe_o`=0, `perr_oe_o`=0, `perr_n_o`=1, and both sticky bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_i | input | 32 | Address/data bus value |
| cbe_i | input | 4 | Command/byte-enable lane value |
| addr_phase_i | input | 1 | Address phase on the bus this clock |
| is_master_i | input | 1 | Device is the initiator of the current transaction |
| is_write_i | input | 1 | Current transaction is a write |
| irdy_i | input | 1 | Initiator ready (active high) |
| trdy_i | input | 1 | Target ready (active high) |
| rpt_en_i | input | 1 | Parity error reporting enable |
| par_i | input | 1 | Parity bit seen on the bus |
| perr_n_i | input | 1 | Error line seen on the bus, active low |
| clr_i | input | 2 | Write-one-to-clear strobes: bit 0 mismatch status, bit 1 target report status |
| par_o | output | 1 | Parity bit to drive |
| par_oe_o | output | 1 | Drive enable for par_o |
| perr_n_o | output | 1 | Error line to drive, active low |
| perr_oe_o | output | 1 | Drive enable for perr_n_o |
| par_err_det_o | output | 1 | Sticky: a parity mismatch was seen |
| tgt_perr_o | output | 1 | Sticky: the target reported an error on a master write |

## Verification
Two functions can fall on the same clock edge: a sticky bit being set and the write-one-to-clear strobe for that bit. The sweep repeats every combination of role, direction, phase, handshake, enable, injected parity fault and injected target error. In the second pass the clear strobe is raised in exactly the clock whose edge records the new mismatch or the target's report. The expected result is that the bit reads 1 afterwards, and a following strobe on its own then clears it to 0.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    // Pipeline state carried from the phase clock to the compare clock and beyond
    typedef struct packed {
        logic s1_gen;    // device drives parity in the next clock
        logic s1_chk;    // parity must be compared in the next clock
        logic s1_chkd;   // the compare belongs to a data phase
        logic s1_rpt;    // reporting enable captured in the phase clock
        logic s1_mw;     // completed master write data phase
        logic s1_par;    // computed parity of the phase
        logic perr;      // error line is being pulled
        logic mw2;       // window for watching the target's error line
    } pipe_t;

    typedef struct packed {
        logic det;
        logic tgt;
    } sticky_t;

endpackage

// File: rtl/bpar_xor_tree.sv
module bpar_xor_tree #(
    parameter int W   = 36,
    parameter int GRP = 4
) (
    input  logic [W-1:0] vec_i,
    output logic         par_o
);
    localparam int NG = (W + GRP - 1) / GRP;
    localparam int PW = NG * GRP;

    logic [PW-1:0] pad;
    logic [NG-1:0] grp;

    assign pad = PW'(vec_i);

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp[g] = ^pad[g*GRP +: GRP];
    end

    assign par_o = ^grp;
endmodule

// File: rtl/bpar_role_decode.sv
module bpar_role_decode (
    input  logic addr_phase_i,
    input  logic is_master_i,
    input  logic is_write_i,
    input  logic irdy_i,
    input  logic trdy_i,
    output logic gen_o,
    output logic chk_o,
    output logic chk_data_o,
    output logic mw_o
);
    logic data_done;
    logic drv_dir;

    always_comb begin
        data_done  = !addr_phase_i && irdy_i && trdy_i;
        // master write and target read share "master equals write"
        drv_dir    = (is_master_i == is_write_i);
        gen_o      = (addr_phase_i && is_master_i) || (data_done && drv_dir);
        chk_data_o = data_done && !drv_dir;
        chk_o      = (addr_phase_i && !is_master_i) || chk_data_o;
        mw_o       = data_done && is_master_i && is_write_i;
    end
endmodule

// File: rtl/bpar_pipe.sv
module bpar_pipe
    import bpar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gen_i,
    input  logic chk_i,
    input  logic chk_data_i,
    input  logic mw_i,
    input  logic rpt_en_i,
    input  logic par_calc_i,
    input  logic par_i,
    input  logic perr_n_i,
    output logic par_o,
    output logic par_oe_o,
    output logic perr_n_o,
    output logic perr_oe_o,
    output logic mismatch_o,
    output logic tgt_seen_o
);
    pipe_t st_d, st_q;
    logic  miss;

    always_comb begin
        miss          = st_q.s1_chk && (par_i != st_q.s1_par);
        st_d          = st_q;
        st_d.s1_gen   = gen_i;
        st_d.s1_chk   = chk_i;
        st_d.s1_chkd  = chk_data_i;
        st_d.s1_rpt   = rpt_en_i;
        st_d.s1_mw    = mw_i;
        st_d.s1_par   = par_calc_i;
        st_d.perr     = miss && st_q.s1_chkd && st_q.s1_rpt;
        st_d.mw2      = st_q.s1_mw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign par_o      = st_q.s1_par;
    assign par_oe_o   = st_q.s1_gen;
    assign perr_n_o   = !st_q.perr;
    assign perr_oe_o  = st_q.perr;
    assign mismatch_o = miss;
    assign tgt_seen_o = st_q.mw2 && !perr_n_i;
endmodule

// File: rtl/bpar_sticky.sv
module bpar_sticky
    import bpar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_det_i,
    input  logic       set_tgt_i,
    input  logic [1:0] clr_i,
    output logic       det_o,
    output logic       tgt_o
);
    sticky_t sk_d, sk_q;

    always_comb begin
        sk_d.det = set_det_i || (sk_q.det && !clr_i[0]);
        sk_d.tgt = set_tgt_i || (sk_q.tgt && !clr_i[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= '0;
        else        sk_q <= sk_d;
    end

    assign det_o = sk_q.det;
    assign tgt_o = sk_q.tgt;
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
    parameter int DATA_W = 32,
    parameter int CBE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [CBE_W-1:0]  cbe_i,
    input  logic              addr_phase_i,
    input  logic              is_master_i,
    input  logic              is_write_i,
    input  logic              irdy_i,
    input  logic              trdy_i,
    input  logic              rpt_en_i,
    input  logic              par_i,
    input  logic              perr_n_i,
    input  logic [1:0]        clr_i,
    output logic              par_o,
    output logic              par_oe_o,
    output logic              perr_n_o,
    output logic              perr_oe_o,
    output logic              par_err_det_o,
    output logic              tgt_perr_o
);
    localparam int TOT_W = DATA_W + CBE_W;

    logic gen, chk, chk_data, mw, par_calc, mismatch, tgt_seen;

    bpar_xor_tree #(.W(TOT_W), .GRP(4)) u_tree (
        .vec_i ({cbe_i, ad_i}),
        .par_o (par_calc)
    );

    bpar_role_decode u_dec (
        .addr_phase_i (addr_phase_i),
        .is_master_i  (is_master_i),
        .is_write_i   (is_write_i),
        .irdy_i       (irdy_i),
        .trdy_i       (trdy_i),
        .gen_o        (gen),
        .chk_o        (chk),
        .chk_data_o   (chk_data),
        .mw_o         (mw)
    );

    bpar_pipe u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .gen_i      (gen),
        .chk_i      (chk),
        .chk_data_i (chk_data),
        .mw_i       (mw),
        .rpt_en_i   (rpt_en_i),
        .par_calc_i (par_calc),
        .par_i      (par_i),
        .perr_n_i   (perr_n_i),
        .par_o      (par_o),
        .par_oe_o   (par_oe_o),
        .perr_n_o   (perr_n_o),
        .perr_oe_o  (perr_oe_o),
        .mismatch_o (mismatch),
        .tgt_seen_o (tgt_seen)
    );

    bpar_sticky u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_det_i (mismatch),
        .set_tgt_i (tgt_seen),
        .clr_i     (clr_i),
        .det_o     (par_err_det_o),
        .tgt_o     (tgt_perr_o)
    );
endmodule

// File: rtl/bpar_checker.sv
module bpar_checker #(
    parameter int DATA_W = 32,
    parameter int CBE_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] ad_i,
    input logic [CBE_W-1:0]  cbe_i,
    input logic              addr_phase_i,
    input logic              is_master_i,
    input logic              is_write_i,
    input logic              irdy_i,
    input logic              trdy_i,
    input logic              rpt_en_i,
    input logic              par_i,
    input logic              perr_n_i,
    input logic [1:0]        clr_i,
    input logic              par_o,
    input logic              par_oe_o,
    input logic              perr_n_o,
    input logic              perr_oe_o,
    input logic              par_err_det_o,
    input logic              tgt_perr_o
);
    a_r1_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe_o |-> (par_o == ^$past({cbe_i, ad_i})));

    a_r2_drive_cause: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe_o |-> ($past(addr_phase_i && is_master_i) ||
                      $past(!addr_phase_i && irdy_i && trdy_i && (is_master_i == is_write_i))));

    a_r3_data_needs_both_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (par_oe_o && !$past(addr_phase_i)) |-> $past(irdy_i && trdy_i));

    a_r5_report_gated: assert property (@(posedge clk) disable iff (!rst_n)
        perr_oe_o |-> ($past(rpt_en_i, 2) && $past(!addr_phase_i && irdy_i && trdy_i, 2)));

    a_r5_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        perr_oe_o |-> !perr_n_o);

    a_r6_det_cleared_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(par_err_det_o) |-> $past(clr_i[0]));

    a_r7_tgt_from_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_perr_o) |-> ($past(!perr_n_i) &&
                               $past(is_master_i && is_write_i && irdy_i && trdy_i, 3)));

    a_r8_tgt_cleared_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_perr_o) |-> $past(clr_i[1]));
endmodule

bind bus_parity_unit bpar_checker #(.DATA_W(DATA_W), .CBE_W(CBE_W)) u_chk (.*);

// File: tb/tb_bus_parity_unit.sv
`timescale 1ns/1ps
module tb_bus_parity_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        addr_phase_i = 1'b0, is_master_i = 1'b0, is_write_i = 1'b0;
    logic        irdy_i = 1'b0, trdy_i = 1'b0, rpt_en_i = 1'b0;
    logic        par_i = 1'b0, perr_n_i = 1'b1;
    logic [1:0]  clr_i = '0;
    logic        par_o, par_oe_o, perr_n_o, perr_oe_o, par_err_det_o, tgt_perr_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bus_parity_unit dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_phase(input logic ap, input logic m, input logic w,
                             input logic ir, input logic tr, input logic rp,
                             input logic cor, input logic tp, input logic race,
                             input logic [31:0] ad, input logic [3:0] cbe);
        logic done, gen, ck, ckd, mwr, ep;
        done = !ap && ir && tr;
        gen  = (ap && m) || (done && (m == w));
        ckd  = done && (m != w);
        ck   = (ap && !m) || ckd;
        mwr  = done && m && w;
        ep   = ^{cbe, ad};
        // phase clock
        @(negedge clk);
        addr_phase_i = ap; is_master_i = m; is_write_i = w;
        irdy_i = ir; trdy_i = tr; rpt_en_i = rp; ad_i = ad; cbe_i = cbe;
        // clock after the phase
        @(negedge clk);
        addr_phase_i = 0; irdy_i = 0; trdy_i = 0; rpt_en_i = 0;
        chk("R2 par_oe", par_oe_o, gen);
        chk("R3/R5 no early error drive", perr_oe_o, 0);
        if (gen) chk("R1 parity value", par_o, ep);
        par_i = ep ^ cor;
        if (race) clr_i = 2'b01;
        // two clocks after the phase
        @(negedge clk);
        par_i = 0; clr_i = race ? 2'b10 : 2'b00;
        perr_n_i = tp ? 1'b0 : 1'b1;
        chk("R5 perr_oe", perr_oe_o, cor && ckd && rp);
        chk("R5 perr_n", perr_n_o, !(cor && ckd && rp));
        chk("R4/R6/R8 det sticky", par_err_det_o, cor && ck);
        // three clocks after
        @(negedge clk);
        perr_n_i = 1'b1;
        chk("R5 one-clock pulse", perr_oe_o, 0);
        chk("R7/R8 tgt sticky", tgt_perr_o, mwr && tp);
        chk("R6 det held", par_err_det_o, cor && ck);
        clr_i = 2'b11;
        @(negedge clk);
        clr_i = 2'b00;
        chk("R8 clear det", par_err_det_o, 0);
        chk("R8 clear tgt", tgt_perr_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 par_oe", par_oe_o, 0);
        chk("R9 perr_oe", perr_oe_o, 0);
        chk("R9 perr_n", perr_n_o, 1);
        chk("R9 det", par_err_det_o, 0);
        chk("R9 tgt", tgt_perr_o, 0);
        rst_n = 1'b1;
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 256; i++) begin
                logic [7:0] b;
                logic [31:0] ad;
                b  = i[7:0];
                ad = 32'h9E37_79B9 * (i + 1) + 32'(pass * 32'h1357_2468);
                run_phase(b[7], b[6], b[5], b[4], b[3], b[2], b[1], b[0],
                          pass[0], ad, 4'(i ^ (i >> 4)));
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule